// File: doc/BRIEF.md
# Drawing Command Queue with Free-Slot Reporting

This block sits between a host register port and a drawing engine. The host writes the parameter words of drawing commands into a queue, and the engine drains them in order. The host does not have to wait for earlier commands to finish before it issues new ones. The host can read a status register at any time. That register holds the exact number of empty slots, so before it starts a multi-word command the host can confirm that every word of the command will fit.

Two ways of waiting are supported. The host can busy-wait by polling the free-slot count. It can also program a threshold and enable a level interrupt, which stays high for as long as the free count is at or above that threshold. A sticky overflow flag records any word that the host wrote while the queue had no room. An idle bit shows when the queue is empty and the engine reports that it is not busy.

Top module: `drawcmd_queue`

## Requirements
- R1: After reset the free count equals DEPTH, the queue is empty (`eng_valid` low), the overflow flag is 0, the control register reads 0 and `irq` is low.
- R2: A host write to address 0 while the free count is nonzero stores `host_wdata` in the queue. The free count, read at address 1 in bits [CNT_W-1:0], is one lower from the next cycle.
- R3: The engine sees the words in the order they were written. `eng_word` shows the oldest word while `eng_valid` is high. Raising `eng_pop` for one cycle removes that word and raises the free count by one.
- R4: A write to address 0 while the free count is 0 is dropped, even if the engine pops in the same cycle, and it sets the overflow flag (status bit 16). The stored words are unchanged.
- R5: The overflow flag stays set until the host writes address 1 with bit 16 equal to 1. A write there with bit 16 equal to 0 leaves the flag set.
- R6: A push and a pop in the same cycle, while the queue is neither empty nor full, leave the free count unchanged and keep the word order.
- R7: A pop while the queue is empty is ignored. The free count stays at DEPTH, and the next word pushed is the next one presented.
- R8: `irq` is high exactly when the enable bit (control bit 0) is 1 and the free count is greater than or equal to the threshold (control bits [8 +: CNT_W]). It is a level signal.
- R9: The idle bit (status bit 17) is 1 only when the queue is empty and `eng_busy` is low.
- R10: A write to address 2 sets the enable bit and the threshold, and a read of address 2 returns them in the same bit positions. Address 3 and address 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 push, 1 status, 2 control, 3 reserved |
| host_wdata | input | WIDTH | Host write data |
| host_rdata | output | WIDTH | Combinational read data for `host_addr` |
| eng_pop | input | 1 | Engine takes the presented word |
| eng_busy | input | 1 | Engine is still executing a command |
| eng_valid | output | 1 | A word is waiting for the engine |
| eng_word | output | WIDTH | Oldest queued word |
| irq | output | 1 | Level interrupt: enough free slots |

## Verification
The bench builds the block with DEPTH set to 8 and WIDTH set to 32. With a depth of 8, a handful of writes fills the queue, so the full-queue drop, the overflow flag and the full-queue push-with-pop case can all be reached in short directed tasks. With a 4-bit free count, the threshold boundary of the interrupt is tested at an exact value, one step below it and one step above it.

// File: rtl/drawcmd_queue_pkg.sv
package drawcmd_queue_pkg;

    // Host register selector
    typedef enum logic [1:0] {
        SEL_PUSH = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    // Bit positions in the status and control words
    localparam int STAT_OVF_BIT  = 16;
    localparam int STAT_IDLE_BIT = 17;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_THR_LSB  = 8;

    // Flags reported in the status word
    typedef struct packed {
        logic idle;
        logic overflow;
    } stat_flags_t;

    // Request decoded from the host port in one cycle
    typedef struct packed {
        logic push;
        logic ovf_clear;
        logic ctrl_load;
    } host_req_t;

    function automatic logic [1:0] step_dir(input logic push_ok, input logic pop_ok);
        return {push_ok, pop_ok};
    endfunction

endpackage

// File: rtl/dcq_store.sv
module dcq_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/dcq_track.sv
module dcq_track
    import drawcmd_queue_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] free_cnt,
    output logic             empty
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);

    logic full;

    assign full    = (free_cnt == '0);
    assign empty   = (free_cnt == FULL_FREE);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            free_cnt <= FULL_FREE;
        end else begin
            if (push_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case (step_dir(push_ok, pop_ok))
                2'b10:   free_cnt <= free_cnt - 1'b1;
                2'b01:   free_cnt <= free_cnt + 1'b1;
                default: free_cnt <= free_cnt;
            endcase
        end
    end

endmodule

// File: rtl/dcq_regs.sv
module dcq_regs
    import drawcmd_queue_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [1:0]       host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic             empty,
    input  logic             eng_busy,
    input  logic             push_dropped,
    output logic             push_req,
    output logic             ovf_clear,
    output logic             idle,
    output logic             overflow,
    output logic             irq,
    output logic [WIDTH-1:0] host_rdata
);

    reg_sel_e         sel;
    host_req_t        req;
    stat_flags_t      flags;
    logic             irq_en;
    logic [CNT_W-1:0] irq_thr;

    assign sel = reg_sel_e'(host_addr);

    always_comb begin
        req           = '0;
        req.push      = host_we && (sel == SEL_PUSH);
        req.ovf_clear = host_we && (sel == SEL_STAT) && host_wdata[STAT_OVF_BIT];
        req.ctrl_load = host_we && (sel == SEL_CTRL);
    end

    assign push_req  = req.push;
    assign ovf_clear = req.ovf_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= 1'b0;
            irq_thr  <= '0;
            overflow <= 1'b0;
        end else begin
            if (req.ctrl_load) begin
                irq_en  <= host_wdata[CTRL_EN_BIT];
                irq_thr <= host_wdata[CTRL_THR_LSB +: CNT_W];
            end
            if (push_dropped) begin
                overflow <= 1'b1;
            end else if (req.ovf_clear) begin
                overflow <= 1'b0;
            end
        end
    end

    assign idle           = empty && !eng_busy;
    assign flags.idle     = idle;
    assign flags.overflow = overflow;
    assign irq            = irq_en && (free_cnt >= irq_thr);

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_STAT: begin
                host_rdata[CNT_W-1:0]     = free_cnt;
                host_rdata[STAT_OVF_BIT]  = flags.overflow;
                host_rdata[STAT_IDLE_BIT] = flags.idle;
            end
            SEL_CTRL: begin
                host_rdata[CTRL_EN_BIT]              = irq_en;
                host_rdata[CTRL_THR_LSB +: CNT_W]    = irq_thr;
            end
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/drawcmd_queue.sv
module drawcmd_queue
    import drawcmd_queue_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [1:0]       host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             eng_pop,
    input  logic             eng_busy,
    output logic             eng_valid,
    output logic [WIDTH-1:0] eng_word,
    output logic             irq
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_req;
    logic             push_ok;
    logic             pop_ok;
    logic             ovf_clear;
    logic             idle;
    logic             overflow;
    logic             empty;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] free_cnt;

    dcq_regs #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .free_cnt     (free_cnt),
        .empty        (empty),
        .eng_busy     (eng_busy),
        .push_dropped (push_req && !push_ok),
        .push_req     (push_req),
        .ovf_clear    (ovf_clear),
        .idle         (idle),
        .overflow     (overflow),
        .irq          (irq),
        .host_rdata   (host_rdata)
    );

    dcq_track #(.DEPTH(DEPTH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (eng_pop),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .free_cnt (free_cnt),
        .empty    (empty)
    );

    dcq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_ptr  (wr_ptr),
        .wr_data (host_wdata),
        .rd_ptr  (rd_ptr),
        .rd_data (eng_word)
    );

    assign eng_valid = !empty;

endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             push_req,
    input logic             eng_pop,
    input logic [CNT_W-1:0] free_cnt,
    input logic             overflow,
    input logic             ovf_clear,
    input logic             idle,
    input logic             eng_valid
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= FULL_FREE); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_req && free_cnt == '0 && !eng_pop) |=> (free_cnt == '0)); // R4

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (push_req && free_cnt == '0) |=> overflow); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clear) |=> overflow); // R5

    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_req && eng_pop && free_cnt != '0 && free_cnt != FULL_FREE)
        |=> $stable(free_cnt)); // R6

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (eng_pop && !push_req && free_cnt == FULL_FREE) |=> (free_cnt == FULL_FREE)); // R7

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        idle |-> !eng_valid); // R9

endmodule

bind drawcmd_queue dcq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .eng_pop   (eng_pop),
    .free_cnt  (free_cnt),
    .overflow  (overflow),
    .ovf_clear (ovf_clear),
    .idle      (idle),
    .eng_valid (eng_valid)
);

// File: tb/drawcmd_queue_bench.sv
module drawcmd_queue_bench;

    localparam int DEPTH = 8;
    localparam int WIDTH = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             host_we = 1'b0;
    logic [1:0]       host_addr = 2'd0;
    logic [WIDTH-1:0] host_wdata = '0;
    logic [WIDTH-1:0] host_rdata;
    logic             eng_pop = 1'b0;
    logic             eng_busy = 1'b0;
    logic             eng_valid;
    logic [WIDTH-1:0] eng_word;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    drawcmd_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_drawcmd_queue (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_pop    (eng_pop),
        .eng_busy   (eng_busy),
        .eng_valid  (eng_valid),
        .eng_word   (eng_word),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: optional push and pop, entered and left at a falling edge
    task automatic cycle(input logic push, input logic [WIDTH-1:0] d, input logic pop);
        host_we    = push;
        host_addr  = 2'd0;
        host_wdata = d;
        eng_pop    = pop;
        @(negedge clk);
        host_we = 1'b0;
        eng_pop = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [WIDTH-1:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [WIDTH-1:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic read_free(output logic [WIDTH-1:0] f);
        logic [WIDTH-1:0] s;
        reg_read(2'd1, s);
        f = s & 32'hF;
    endtask

    task automatic read_ovf(output logic [WIDTH-1:0] o);
        logic [WIDTH-1:0] s;
        reg_read(2'd1, s);
        o = {31'd0, s[16]};
    endtask

    task automatic t_reset;
        logic [WIDTH-1:0] v;
        read_free(v);           check("R1 free after reset", v, DEPTH);
        read_ovf(v);            check("R1 overflow after reset", v, 0);
        check("R1 eng_valid after reset", {31'd0, eng_valid}, 0);
        check("R1 irq after reset", {31'd0, irq}, 0);
        reg_read(2'd2, v);      check("R1 control after reset", v, 0);
        reg_read(2'd1, v);      check("R9 idle after reset", {31'd0, v[17]}, 1);
    endtask

    task automatic t_fill_drain;
        logic [WIDTH-1:0] v;
        cycle(1, 32'hA001, 0);
        cycle(1, 32'hA002, 0);
        cycle(1, 32'hA003, 0);
        read_free(v);           check("R2 free after 3 pushes", v, DEPTH - 3);
        check("R3 first word", eng_word, 32'hA001);
        for (int i = 1; i <= 3; i++) begin
            check("R3 word order", eng_word, 32'hA000 + i);
            cycle(0, 0, 1);
            read_free(v);       check("R3 free after pop", v, DEPTH - 3 + i);
        end
        check("R3 empty after drain", {31'd0, eng_valid}, 0);
    endtask

    task automatic t_overflow;
        logic [WIDTH-1:0] v;
        for (int i = 0; i < DEPTH; i++) cycle(1, 32'hB000 + i, 0);
        read_free(v);           check("R2 free when full", v, 0);
        read_ovf(v);            check("R4 overflow before drop", v, 0);
        cycle(1, 32'hDEAD, 0);
        read_free(v);           check("R4 free after dropped push", v, 0);
        read_ovf(v);            check("R4 overflow set", v, 1);
        reg_write(2'd1, 32'h0);
        read_ovf(v);            check("R5 overflow kept on write of 0", v, 1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R4 stored words unchanged", eng_word, 32'hB000 + i);
            cycle(0, 0, 1);
        end
        check("R4 no extra word", {31'd0, eng_valid}, 0);
        read_ovf(v);            check("R5 overflow kept after drain", v, 1);
        reg_write(2'd1, 32'h0001_0000);
        read_ovf(v);            check("R5 overflow cleared by write 1", v, 0);
    endtask

    task automatic t_full_pushpop;
        logic [WIDTH-1:0] v;
        for (int i = 0; i < DEPTH; i++) cycle(1, 32'hC000 + i, 0);
        cycle(1, 32'hBEEF, 1);
        read_free(v);           check("R4 full push with pop dropped", v, 1);
        read_ovf(v);            check("R4 overflow on full push with pop", v, 1);
        for (int i = 1; i < DEPTH; i++) begin
            check("R4 order after full push with pop", eng_word, 32'hC000 + i);
            cycle(0, 0, 1);
        end
        check("R4 dropped word absent", {31'd0, eng_valid}, 0);
        reg_write(2'd1, 32'h0001_0000);
    endtask

    task automatic t_simul;
        logic [WIDTH-1:0] v;
        cycle(1, 32'hD001, 0);
        cycle(1, 32'hD002, 0);
        cycle(1, 32'hD003, 1);
        read_free(v);           check("R6 free held on push with pop", v, DEPTH - 2);
        check("R6 order after push with pop", eng_word, 32'hD002);
        cycle(0, 0, 1);
        check("R6 last word", eng_word, 32'hD003);
        cycle(0, 0, 1);
    endtask

    task automatic t_pop_empty;
        logic [WIDTH-1:0] v;
        cycle(0, 0, 1);
        cycle(0, 0, 1);
        read_free(v);           check("R7 free after empty pop", v, DEPTH);
        cycle(1, 32'hE001, 0);
        check("R7 next word presented", eng_word, 32'hE001);
        read_free(v);           check("R7 free after push", v, DEPTH - 1);
        cycle(0, 0, 1);
    endtask

    task automatic t_irq;
        logic [WIDTH-1:0] v;
        check("R8 irq while disabled", {31'd0, irq}, 0);
        reg_write(2'd2, 32'h0000_0501);
        reg_read(2'd2, v);      check("R10 control readback", v, 32'h0000_0501);
        reg_read(2'd3, v);      check("R10 reserved reads 0", v, 0);
        reg_read(2'd0, v);      check("R10 push address reads 0", v, 0);
        check("R8 irq free 8 thr 5", {31'd0, irq}, 1);
        for (int i = 0; i < 3; i++) cycle(1, 32'hF000 + i, 0);
        check("R8 irq free 5 thr 5", {31'd0, irq}, 1);
        cycle(1, 32'hF003, 0);
        check("R8 irq free 4 thr 5", {31'd0, irq}, 0);
        cycle(0, 0, 1);
        check("R8 irq back at free 5", {31'd0, irq}, 1);
        reg_write(2'd2, 32'h0000_0500);
        check("R8 irq off when disabled", {31'd0, irq}, 0);
        for (int i = 0; i < 3; i++) cycle(0, 0, 1);
    endtask

    task automatic t_idle;
        logic [WIDTH-1:0] v;
        eng_busy = 1'b1;
        reg_read(2'd1, v);      check("R9 idle low when busy", {31'd0, v[17]}, 0);
        eng_busy = 1'b0;
        cycle(1, 32'h1234, 0);
        reg_read(2'd1, v);      check("R9 idle low when not empty", {31'd0, v[17]}, 0);
        cycle(0, 0, 1);
        reg_read(2'd1, v);      check("R9 idle high when drained", {31'd0, v[17]}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_overflow();
        t_full_pushpop();
        t_simul();
        t_pop_empty();
        t_irq();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule